// File: doc/BRIEF.md
# Remote Terminal Subaddress Message Indexer

This block sits between the word-level protocol engine of a serial-bus remote terminal and a synchronous RAM port. For every accepted command it looks up a four-word descriptor for the addressed subaddress and direction, then steers each data word of the message to or from a message slot in that subaddress's buffer area. When the message ends, it records one status entry per message in a separate sequential list.

Every subaddress and direction pair has its own running index and its own slot counter. The index counts every message and selects the status entry. The slot counter moves forward only for messages reported valid, so a bad message leaves its buffer space to be reused by the next one. At a programmed limit both counters return to zero. An interrupt pulse can be raised on every access, on reaching the limit, or on both. A subaddress whose descriptor carries the illegal flag is rejected before any word is moved.

Descriptor layout, relative to `DESC_BASE + tx*128 + sa*4`: word 0 is control (bits [6:0] limit with 0 meaning 128, bit 8 interrupt-per-access enable, bit 9 interrupt-at-limit enable, bit 15 illegal), word 1 is the data area base, word 2 is the status list base, and word 3 is the current position (bits [6:0] index, bits [14:8] slot).

Top module: `rt_msg_index`

## Requirements
- R1: After reset, ready_o, illegal_o, irq_o, irq_cause_o, mem_we_o and mem_re_o are all low until a command arrives.
- R2: A command reads the descriptor at DESC_BASE + tx*128 + sa*4 (control, data base, status base, current word, in that order) before ready_o is raised, and each subaddress/direction pair keeps independent state.
- R3: If control bit 15 is set, illegal_o pulses for one cycle, ready_o is never raised, and no RAM location (data, status list or descriptor) is written.
- R4: In a receive message, data word k is written to data_base + slot*32 + k, in arrival order.
- R5: In a transmit message, word k is read from data_base + slot*32 + k and presented on tx_word_o with tx_vld_o high in the cycle after its strobe.
- R6: At message end the status entry {valid[15], word_count[14:10], time_tag[9:0]} is written to status_base + index, for valid and invalid messages alike.
- R7: Descriptor word 3 is rewritten with index+1, and slot+1 only if the message was valid; an invalid message leaves the slot unchanged.
- R8: When index+1 equals the limit (a limit field of 0 means 128), index and slot are both written back as 0.
- R9: With control bit 9 set, a message that hits the limit raises a one-cycle irq_o with irq_cause_o bit 1 set.
- R10: With control bit 8 set, every message raises a one-cycle irq_o with irq_cause_o bit 0 set; with bits 8 and 9 clear, no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Decoded command strobe, accepted when idle |
| cmd_sa_i | input | 5 | Subaddress of the command |
| cmd_tx_i | input | 1 | 1 for transmit, 0 for receive |
| cmd_wc_i | input | 5 | Word count field of the command |
| word_stb_i | input | 1 | One data word to move (while ready_o) |
| word_i | input | 16 | Received data word |
| msg_end_i | input | 1 | Message finished (while ready_o) |
| msg_ok_i | input | 1 | Message valid flag, with msg_end_i |
| ttag_i | input | 10 | Time tag, with msg_end_i |
| ready_o | output | 1 | Descriptor loaded, accepting words |
| illegal_o | output | 1 | Command rejected as illegal |
| irq_o | output | 1 | Interrupt pulse |
| irq_cause_o | output | 2 | Bit 0 access, bit 1 limit reached |
| tx_word_o | output | 16 | Transmit data word |
| tx_vld_o | output | 1 | tx_word_o valid |
| mem_addr_o | output | 16 | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_re_o | output | 1 | RAM read enable |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data, one cycle after mem_re_o |

## Verification
A corrupted index or slot shows at the ports within the same message: the status entry lands at the wrong list address and the written-back position word differs, both visible in RAM three cycles after msg_end_i. A wrong slot also moves data words away from base + slot*32, and a missed limit comparison shows as a missing or extra interrupt one cycle after the status write. The sweep drives each configured subaddress through many messages with mixed validity, word counts including the 32-word case, and a full 128-message run, so errors accumulate into mismatches rather than hiding.

// File: rtl/rt_idx_pkg.sv
package rt_idx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_CHK, ST_XFER, ST_WB0, ST_WB1
  } idx_state_e;

  localparam int CTL_ACC_BIT  = 8;
  localparam int CTL_LIM_BIT  = 9;
  localparam int CTL_ILL_BIT  = 15;
  localparam int CUR_SLOT_LSB = 8;

  localparam logic [1:0] OFF_CTL = 2'd0;
  localparam logic [1:0] OFF_DB  = 2'd1;
  localparam logic [1:0] OFF_SB  = 2'd2;
  localparam logic [1:0] OFF_CUR = 2'd3;
endpackage

// File: rtl/rt_idx_next.sv
module rt_idx_next #(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] slot_i,
  input  logic [IDX_W-1:0] lim_i,
  input  logic             ok_i,
  output logic [IDX_W-1:0] idx_n_o,
  output logic [IDX_W-1:0] slot_n_o,
  output logic             wrap_o
);
  logic [IDX_W:0] lim_eff, inc;

  always_comb begin
    // zero limit field selects the full counter range
    lim_eff  = (lim_i == '0) ? {1'b1, {IDX_W{1'b0}}} : {1'b0, lim_i};
    inc      = {1'b0, idx_i} + 1'b1;
    wrap_o   = (inc == lim_eff);
    idx_n_o  = wrap_o ? '0 : inc[IDX_W-1:0];
    slot_n_o = wrap_o ? '0 : (ok_i ? slot_i + 1'b1 : slot_i);
  end
endmodule

// File: rtl/rt_idx_addr.sv
module rt_idx_addr #(
  parameter int              ADDR_W    = 16,
  parameter int              SA_W      = 5,
  parameter int              WC_W      = 5,
  parameter int              IDX_W     = 7,
  parameter logic [ADDR_W-1:0] DESC_BASE = 16'h0400
) (
  input  logic              tx_i,
  input  logic [SA_W-1:0]   sa_i,
  input  logic [1:0]        off_i,
  input  logic [ADDR_W-1:0] dbase_i,
  input  logic [ADDR_W-1:0] sbase_i,
  input  logic [IDX_W-1:0]  slot_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WC_W-1:0]   wcnt_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic [ADDR_W-1:0] stat_addr_o
);
  always_comb begin
    desc_addr_o = DESC_BASE + ADDR_W'({tx_i, sa_i, off_i});
    data_addr_o = dbase_i + ADDR_W'({slot_i, wcnt_i});
    stat_addr_o = sbase_i + ADDR_W'(idx_i);
  end
endmodule

// File: rtl/rt_msg_index.sv
module rt_msg_index
  import rt_idx_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                SA_W      = 5,
  parameter int                WC_W      = 5,
  parameter int                TTAG_W    = 10,
  parameter int                IDX_W     = 7,
  parameter logic [ADDR_W-1:0] DESC_BASE = 16'h0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic [SA_W-1:0]   cmd_sa_i,
  input  logic              cmd_tx_i,
  input  logic [WC_W-1:0]   cmd_wc_i,
  input  logic              word_stb_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              msg_end_i,
  input  logic              msg_ok_i,
  input  logic [TTAG_W-1:0] ttag_i,
  output logic              ready_o,
  output logic              illegal_o,
  output logic              irq_o,
  output logic [1:0]        irq_cause_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_vld_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int STAT_W = 1 + WC_W + TTAG_W;

  idx_state_e        state_q, state_d;
  logic              tx_q;
  logic [SA_W-1:0]   sa_q;
  logic [WC_W-1:0]   wc_q, wcnt_q;
  logic [IDX_W-1:0]  lim_q, idx_q, slot_q;
  logic              acc_en_q, lim_en_q, ill_q;
  logic [ADDR_W-1:0] dbase_q, sbase_q;
  logic              ok_q;
  logic [TTAG_W-1:0] ttag_q;
  logic              tx_vld_q;

  logic [1:0]        off;
  logic [ADDR_W-1:0] desc_addr, data_addr, stat_addr;
  logic [IDX_W-1:0]  idx_n, slot_n;
  logic              wrap;
  logic [DATA_W-1:0] cur_n;
  logic              xfer_word;

  rt_idx_addr #(
    .ADDR_W(ADDR_W), .SA_W(SA_W), .WC_W(WC_W), .IDX_W(IDX_W), .DESC_BASE(DESC_BASE)
  ) u_addr (
    .tx_i(tx_q), .sa_i(sa_q), .off_i(off), .dbase_i(dbase_q), .sbase_i(sbase_q),
    .slot_i(slot_q), .idx_i(idx_q), .wcnt_i(wcnt_q),
    .desc_addr_o(desc_addr), .data_addr_o(data_addr), .stat_addr_o(stat_addr)
  );

  rt_idx_next #(.IDX_W(IDX_W)) u_next (
    .idx_i(idx_q), .slot_i(slot_q), .lim_i(lim_q), .ok_i(ok_q),
    .idx_n_o(idx_n), .slot_n_o(slot_n), .wrap_o(wrap)
  );

  assign xfer_word = (state_q == ST_XFER) && word_stb_i && !msg_end_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_vld_i) state_d = ST_RD0;
      ST_RD0:  state_d = ST_RD1;
      ST_RD1:  state_d = ST_RD2;
      ST_RD2:  state_d = ST_RD3;
      ST_RD3:  state_d = ST_CHK;
      ST_CHK:  state_d = ill_q ? ST_IDLE : ST_XFER;
      ST_XFER: if (msg_end_i) state_d = ST_WB0;
      ST_WB0:  state_d = ST_WB1;
      ST_WB1:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cur_n = '0;
    cur_n[IDX_W-1:0]              = idx_n;
    cur_n[CUR_SLOT_LSB +: IDX_W]  = slot_n;
  end

  always_comb begin
    off         = OFF_CTL;
    mem_addr_o  = desc_addr;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_RD0: begin off = OFF_CTL; mem_re_o = 1'b1; end
      ST_RD1: begin off = OFF_DB;  mem_re_o = 1'b1; end
      ST_RD2: begin off = OFF_SB;  mem_re_o = 1'b1; end
      ST_RD3: begin off = OFF_CUR; mem_re_o = 1'b1; end
      ST_XFER: if (xfer_word) begin
        mem_addr_o  = data_addr;
        mem_we_o    = !tx_q;
        mem_re_o    = tx_q;
        mem_wdata_o = word_i;
      end
      ST_WB0: begin
        mem_addr_o  = stat_addr;
        mem_we_o    = 1'b1;
        mem_wdata_o = DATA_W'({ok_q, wc_q, ttag_q});
      end
      ST_WB1: begin
        off         = OFF_CUR;
        mem_we_o    = 1'b1;
        mem_wdata_o = cur_n;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tx_q     <= 1'b0;
      sa_q     <= '0;
      wc_q     <= '0;
      wcnt_q   <= '0;
      lim_q    <= '0;
      acc_en_q <= 1'b0;
      lim_en_q <= 1'b0;
      ill_q    <= 1'b0;
      dbase_q  <= '0;
      sbase_q  <= '0;
      idx_q    <= '0;
      slot_q   <= '0;
      ok_q     <= 1'b0;
      ttag_q   <= '0;
      tx_vld_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      tx_vld_q <= xfer_word && tx_q;
      unique case (state_q)
        ST_IDLE: if (cmd_vld_i) begin
          sa_q <= cmd_sa_i;
          tx_q <= cmd_tx_i;
          wc_q <= cmd_wc_i;
        end
        ST_RD1: begin
          lim_q    <= mem_rdata_i[IDX_W-1:0];
          acc_en_q <= mem_rdata_i[CTL_ACC_BIT];
          lim_en_q <= mem_rdata_i[CTL_LIM_BIT];
          ill_q    <= mem_rdata_i[CTL_ILL_BIT];
        end
        ST_RD2: dbase_q <= mem_rdata_i;
        ST_RD3: sbase_q <= mem_rdata_i;
        ST_CHK: begin
          idx_q  <= mem_rdata_i[IDX_W-1:0];
          slot_q <= mem_rdata_i[CUR_SLOT_LSB +: IDX_W];
          wcnt_q <= '0;
        end
        ST_XFER: begin
          if (msg_end_i) begin
            ok_q   <= msg_ok_i;
            ttag_q <= ttag_i;
          end else if (word_stb_i) begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_XFER);
  assign illegal_o   = (state_q == ST_CHK) && ill_q;
  assign irq_cause_o = (state_q == ST_WB1) ? {lim_en_q && wrap, acc_en_q} : 2'b00;
  assign irq_o       = |irq_cause_o;
  assign tx_vld_o    = tx_vld_q;
  assign tx_word_o   = mem_rdata_i;

  initial if (STAT_W > DATA_W) $error("status entry wider than data word");

  AST_READY_AFTER_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(mem_re_o, 2)) else $error("ready without descriptor read"); // R2
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> (!mem_we_o && !ready_o)) else $error("illegal command buffered"); // R3
  AST_TX_VLD_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> $past(mem_re_o && ready_o)) else $error("tx word without read"); // R5
  AST_STATUS_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && msg_end_i) |=> (mem_we_o && !mem_re_o)) else $error("no status write"); // R6
  AST_IRQ_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o) else $error("irq longer than one cycle"); // R10
endmodule

// File: tb/rt_msg_index_tb.sv
module rt_msg_index_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0, cmd_tx = 1'b0, word_stb = 1'b0, msg_end = 1'b0, msg_ok = 1'b0;
  logic [4:0]  cmd_sa = '0, cmd_wc = '0;
  logic [15:0] word_in = '0;
  logic [9:0]  ttag = '0;
  logic        ready, illegal, irq, tx_vld, mem_we, mem_re;
  logic [1:0]  irq_cause;
  logic [15:0] tx_word, mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, ill_cnt = 0, tx_n = 0;
  logic [1:0]  last_cause = '0;
  logic [15:0] ram [0:8191];
  logic [15:0] tx_buf [0:1023];

  int          e_lim [0:63], e_idx [0:63], e_slot [0:63];
  bit          e_acc [0:63], e_lirq [0:63], e_ill [0:63];
  logic [15:0] e_db [0:63], e_sb [0:63];

  always #4 clk = ~clk;

  rt_msg_index u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_vld_i(cmd_vld), .cmd_sa_i(cmd_sa), .cmd_tx_i(cmd_tx),
    .cmd_wc_i(cmd_wc), .word_stb_i(word_stb), .word_i(word_in), .msg_end_i(msg_end),
    .msg_ok_i(msg_ok), .ttag_i(ttag), .ready_o(ready), .illegal_o(illegal), .irq_o(irq),
    .irq_cause_o(irq_cause), .tx_word_o(tx_word), .tx_vld_o(tx_vld), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[12:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[12:0]];
  end

  always @(negedge clk) begin
    if (irq) begin irq_cnt++; last_cause = irq_cause; end
    if (illegal) ill_cnt++;
    if (tx_vld) begin tx_buf[tx_n] = tx_word; tx_n++; end
  end

  function automatic logic [15:0] pat(input int a);
    return 16'(a) ^ 16'h5A5A;
  endfunction

  function automatic int desc_of(input bit tx, input int sa);
    return 16'h0400 + tx * 128 + sa * 4;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input bit tx, input int sa, input int lim, input bit acc, input bit lirq,
                       input bit ill, input logic [15:0] db, input logic [15:0] sb,
                       input int idx0, input int slot0);
    int k = tx * 32 + sa;
    int d = desc_of(tx, sa);
    ram[d]     = (16'(ill) << 15) | (16'(lirq) << 9) | (16'(acc) << 8) | 16'(lim % 128);
    ram[d + 1] = db;
    ram[d + 2] = sb;
    ram[d + 3] = 16'((slot0 << 8) | idx0);
    e_lim[k] = lim; e_acc[k] = acc; e_lirq[k] = lirq; e_ill[k] = ill;
    e_db[k] = db; e_sb[k] = sb; e_idx[k] = idx0; e_slot[k] = slot0;
  endtask

  task automatic run_msg(input bit tx, input int sa, input int wc, input bit ok, input int tt);
    int k = tx * 32 + sa;
    int d = desc_of(tx, sa);
    int nw = (wc == 0) ? 32 : wc;
    int irq0 = irq_cnt, ill0 = ill_cnt, txn0 = tx_n;
    int base = e_db[k] + e_slot[k] * 32;
    int lim_eff = (e_lim[k] == 0) ? 128 : e_lim[k];
    bit wrap = (e_idx[k] + 1 == lim_eff);
    int idx_n = wrap ? 0 : e_idx[k] + 1;
    int slot_n = wrap ? 0 : (ok ? (e_slot[k] + 1) % 128 : e_slot[k]);
    bit exp_irq = e_acc[k] | (e_lirq[k] & wrap);
    logic [15:0] cur0 = ram[d + 3];
    logic [15:0] stat0 = ram[e_sb[k] + e_idx[k]];
    @(negedge clk);
    cmd_vld = 1'b1; cmd_tx = tx; cmd_sa = 5'(sa); cmd_wc = 5'(wc);
    @(negedge clk);
    cmd_vld = 1'b0;
    while (!ready && !illegal) @(negedge clk);
    if (illegal) begin
      repeat (3) @(negedge clk);
      chk("R3 illegal pulse count", 16'(ill_cnt - ill0), 16'd1);
      chk("R3 illegal flag set in descriptor", 16'(e_ill[k]), 16'd1);
      chk("R3 position word untouched", ram[d + 3], cur0);
      chk("R3 status list untouched", ram[e_sb[k] + e_idx[k]], stat0);
      chk("R3 no interrupt", 16'(irq_cnt - irq0), 16'd0);
      return;
    end
    chk("R3 legal command accepted", 16'(e_ill[k]), 16'd0);
    for (int w = 0; w < nw; w++) begin
      word_stb = 1'b1;
      word_in = 16'(tt * 7 + w) ^ 16'h3C00;
      @(negedge clk);
    end
    word_stb = 1'b0;
    msg_end = 1'b1; msg_ok = ok; ttag = 10'(tt);
    @(negedge clk);
    msg_end = 1'b0;
    repeat (3) @(negedge clk);
    if (!tx) begin
      for (int w = 0; w < nw; w++)
        chk($sformatf("R4 rx word %0d", w), ram[base + w], 16'(tt * 7 + w) ^ 16'h3C00);
    end else begin
      chk("R5 tx word count", 16'(tx_n - txn0), 16'(nw));
      for (int w = 0; w < nw; w++)
        chk($sformatf("R5 tx word %0d", w), tx_buf[txn0 + w], pat(base + w));
    end
    chk("R2 R6 status entry", ram[e_sb[k] + e_idx[k]], {ok, 5'(wc), 10'(tt)});
    chk(wrap ? "R8 position after limit" : "R7 position advance", ram[d + 3],
        16'((slot_n << 8) | idx_n));
    chk(e_lirq[k] ? "R9 interrupt count" : "R10 interrupt count", 16'(irq_cnt - irq0),
        16'(exp_irq));
    if (exp_irq)
      chk("R9 R10 interrupt cause", 16'(last_cause), 16'({e_lirq[k] & wrap, e_acc[k]}));
    e_idx[k] = idx_n;
    e_slot[k] = slot_n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 8192; a++) ram[a] = pat(a);
    setup(0, 3, 3, 1, 0, 0, 16'h1000, 16'h1800, 0, 0);
    setup(1, 3, 4, 0, 1, 0, 16'h1400, 16'h1880, 2, 1);
    setup(0, 7, 5, 1, 1, 1, 16'h1200, 16'h1840, 1, 0);
    setup(0, 30, 0, 0, 1, 0, 16'h1600, 16'h1A00, 0, 0);
    setup(1, 31, 2, 1, 1, 0, 16'h1700, 16'h1900, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 16'(ready), 16'd0);
    chk("R1 illegal after reset", 16'(illegal), 16'd0);
    chk("R1 irq after reset", 16'({irq, irq_cause}), 16'd0);
    chk("R1 ram strobes after reset", 16'({mem_we, mem_re}), 16'd0);

    for (int m = 0; m < 8; m++) run_msg(0, 3, (m * 5) % 32, (m % 3) != 1, m * 37);
    for (int m = 0; m < 6; m++) run_msg(1, 3, m + 1, m != 2, 100 + m);
    run_msg(0, 7, 4, 1, 11);
    for (int m = 0; m < 3; m++) run_msg(1, 31, 2 + m, 1, 200 + m);
    run_msg(0, 7, 1, 0, 12);
    for (int m = 0; m < 130; m++) run_msg(0, 30, 1 + (m % 4), (m % 16) == 0, m);
    run_msg(0, 3, 0, 1, 999);
    run_msg(1, 3, 3, 1, 321);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule